// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home-side engine that keeps the caches of a distributed shared-memory machine coherent for a range of memory blocks. For every block it records a directory entry: a state (Uncached, Shared or Exclusive) and a presence vector with one bit per processor. In Exclusive state the single set bit names the owning processor.

Miss and write-back requests arrive on a valid/ready request channel. Each request carries a processor number, a block address and, for a write-back, the block data. The controller accepts one request at a time and keeps strict arrival order. It updates the directory entry and emits the coherence traffic that the request needs on a valid/ready message channel: invalidates, fetches, fetch-with-invalidate and data replies. When the owner's copy must be pulled back, the owner returns the block on a response channel. The backing memory sits outside the block and is reached through a read port with a combinational result and a write strobe that takes effect at the clock edge.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every directory entry is Uncached, `req_ready` is 1, `out_valid` is 0 and `mem_we` is 0.
- R2: A read miss (req_kind 0) on an Uncached block produces one data reply (out_kind 3) to the requester, carrying the memory contents. The entry becomes Shared with the requester as the only sharer.
- R3: A write miss (req_kind 1) on an Uncached block produces one data reply carrying memory data. The entry becomes Exclusive with the requester as owner.
- R4: A read miss on a Shared block replies with memory data and adds the requester to the sharers. Earlier sharers are kept.
- R5: A write miss on a Shared block first sends one invalidate (out_kind 0) to each sharer other than the requester, in ascending processor order. It then sends a data reply with memory data. The entry becomes Exclusive with the requester as owner.
- R6: A read miss on an Exclusive block sends a fetch (out_kind 1) to the owner and waits for its response. It writes the returned block to memory and replies to the requester with that block. The entry becomes Shared with both owner and requester.
- R7: A write miss on an Exclusive block sends a fetch-with-invalidate (out_kind 2) to the owner. It forwards the returned block to the requester without writing memory. The entry stays Exclusive with the requester as the new owner.
- R8: A write-back (req_kind 2) from the owner of an Exclusive block writes its data to memory in the cycle of acceptance and sends no message. The entry becomes Uncached with no sharers.
- R9: A write-back from any processor that does not own the block in Exclusive state is ignored: no memory write, no message, no entry change. Reserved request kind 3 is ignored in the same way.
- R10: After a miss is accepted, `req_ready` stays 0 until the handshake of its data reply. A write-back leaves `req_ready` at 1. Requests complete in the order they were accepted.
- R11: While `out_valid` is 1 and `out_ready` is 0, the message (kind, destination, address, data) holds steady and `out_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 reserved |
| req_proc | input | PW | Requesting processor |
| req_addr | input | AW | Block address |
| req_data | input | DW | Write-back data |
| out_valid | output | 1 | Message present |
| out_ready | input | 1 | Network accepts the message |
| out_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch-with-invalidate, 3 data reply |
| out_dest | output | PW | Destination processor |
| out_addr | output | AW | Block address of the message |
| out_data | output | DW | Reply data (zero for other kinds) |
| rsp_valid | input | 1 | Owner's fetched block present |
| rsp_ready | output | 1 | Controller waits for the owner's block |
| rsp_data | input | DW | Owner's block |
| mem_addr | output | AW | Memory address |
| mem_rdata | input | DW | Memory read data, combinational from mem_addr |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |

## Verification
The assertions assume that the owner's response arrives only after a fetch has been sent, and that the environment never sends a miss from a processor for a block it already owns in Exclusive state. The stimulus respects both rules. It turns any such random miss into a write-back, and it drives `rsp_valid` only after observing a fetch handshake. A behavioural reference model in the bench keeps its own directory, memory image and owner copies. It predicts the exact message sequence for each request. The bench holds `out_ready` low at random to stall the message channel.

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NPROC = 4,
  parameter int NBLK  = 16,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_kind,
  input  logic [$clog2(NPROC)-1:0] req_proc,
  input  logic [$clog2(NBLK)-1:0]  req_addr,
  input  logic [DW-1:0]            req_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [1:0]               out_kind,
  output logic [$clog2(NPROC)-1:0] out_dest,
  output logic [$clog2(NBLK)-1:0]  out_addr,
  output logic [DW-1:0]            out_data,
  input  logic                     rsp_valid,
  output logic                     rsp_ready,
  input  logic [DW-1:0]            rsp_data,
  output logic [$clog2(NBLK)-1:0]  mem_addr,
  input  logic [DW-1:0]            mem_rdata,
  output logic                     mem_we,
  output logic [DW-1:0]            mem_wdata
);
  localparam int PW = $clog2(NPROC);
  localparam int AW = $clog2(NBLK);

  localparam logic [1:0] RQ_RD = 2'd0, RQ_WR = 2'd1, RQ_WB = 2'd2;
  localparam logic [1:0] MS_INV = 2'd0, MS_FETCH = 2'd1, MS_FINV = 2'd2, MS_DATA = 2'd3;
  localparam logic [1:0] DS_UNC = 2'd0, DS_SHR = 2'd1, DS_EXC = 2'd2;

  typedef enum logic [2:0] {ST_IDLE, ST_INV, ST_FETCH, ST_WAIT, ST_REPLY} phase_t;

  phase_t            phase;
  logic [1:0]        dstate [NBLK];
  logic [NPROC-1:0]  dshare [NBLK];
  logic [PW-1:0]     who_q, owner_q;
  logic [AW-1:0]     blk_q;
  logic [NPROC-1:0]  pend_q;
  logic [DW-1:0]     held_q;
  logic              use_held_q, rd_q;
  logic [1:0]        fkind_q;

  function automatic logic [PW-1:0] low_idx(input logic [NPROC-1:0] v);
    logic [PW-1:0] r;
    r = '0;
    for (int i = NPROC - 1; i >= 0; i--)
      if (v[i]) r = PW'(i);
    return r;
  endfunction

  logic [1:0]       cur_st;
  logic [NPROC-1:0] cur_sh, me_bit, others, inv_bit;
  logic [PW-1:0]    cur_own, inv_dest;
  logic             take, wb_hit;

  assign cur_st   = dstate[req_addr];
  assign cur_sh   = dshare[req_addr];
  assign me_bit   = NPROC'(1) << req_proc;
  assign others   = cur_sh & ~me_bit;
  assign cur_own  = low_idx(cur_sh);
  assign inv_dest = low_idx(pend_q);
  assign inv_bit  = NPROC'(1) << inv_dest;
  assign take     = req_valid && req_ready;
  assign wb_hit   = (req_kind == RQ_WB) && (cur_st == DS_EXC) && (cur_sh == me_bit);

  assign req_ready = (phase == ST_IDLE);
  assign rsp_ready = (phase == ST_WAIT);
  assign out_valid = (phase == ST_INV) || (phase == ST_FETCH) || (phase == ST_REPLY);
  assign out_kind  = (phase == ST_INV) ? MS_INV : (phase == ST_FETCH) ? fkind_q : MS_DATA;
  assign out_dest  = (phase == ST_INV) ? inv_dest : (phase == ST_FETCH) ? owner_q : who_q;
  assign out_addr  = blk_q;
  assign out_data  = (phase != ST_REPLY) ? '0 : (use_held_q ? held_q : mem_rdata);
  assign mem_addr  = (phase == ST_IDLE) ? req_addr : blk_q;
  assign mem_we    = (take && wb_hit) || ((phase == ST_WAIT) && rsp_valid && rd_q);
  assign mem_wdata = (phase == ST_IDLE) ? req_data : rsp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= ST_IDLE;
      who_q      <= '0;
      owner_q    <= '0;
      blk_q      <= '0;
      pend_q     <= '0;
      held_q     <= '0;
      use_held_q <= 1'b0;
      rd_q       <= 1'b0;
      fkind_q    <= MS_FETCH;
      for (int b = 0; b < NBLK; b++) begin
        dstate[b] <= DS_UNC;
        dshare[b] <= '0;
      end
    end else begin
      case (phase)
        ST_IDLE: if (take) begin
          who_q      <= req_proc;
          blk_q      <= req_addr;
          owner_q    <= cur_own;
          use_held_q <= 1'b0;
          case (req_kind)
            RQ_RD: begin
              rd_q <= 1'b1;
              dstate[req_addr] <= DS_SHR;
              dshare[req_addr] <= (cur_st == DS_UNC) ? me_bit : (cur_sh | me_bit);
              if (cur_st == DS_EXC) begin
                fkind_q <= MS_FETCH;
                phase   <= ST_FETCH;
              end else begin
                phase   <= ST_REPLY;
              end
            end
            RQ_WR: begin
              rd_q <= 1'b0;
              dstate[req_addr] <= DS_EXC;
              dshare[req_addr] <= me_bit;
              if (cur_st == DS_EXC) begin
                fkind_q <= MS_FINV;
                phase   <= ST_FETCH;
              end else if (cur_st == DS_SHR && others != '0) begin
                pend_q <= others;
                phase  <= ST_INV;
              end else begin
                phase  <= ST_REPLY;
              end
            end
            RQ_WB: if (wb_hit) begin
              dstate[req_addr] <= DS_UNC;
              dshare[req_addr] <= '0;
            end
            default: ;
          endcase
        end
        ST_INV: if (out_ready) begin
          pend_q <= pend_q & ~inv_bit;
          if ((pend_q & ~inv_bit) == '0) phase <= ST_REPLY;
        end
        ST_FETCH: if (out_ready) phase <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          held_q     <= rsp_data;
          use_held_q <= 1'b1;
          phase      <= ST_REPLY;
        end
        ST_REPLY: if (out_ready) phase <= ST_IDLE;
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_dest)
                                   && $stable(out_addr) && $stable(out_data)));

  assert_miss_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_kind == RQ_RD || req_kind == RQ_WR)) |=> !req_ready);

  assert_inv_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_kind == MS_INV) |=>
      (!(out_valid && out_kind == MS_INV) || (out_dest > $past(out_dest))));

  assert_fetch_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && (out_kind == MS_FETCH || out_kind == MS_FINV)) |=>
      (!out_valid && !req_ready));

  assert_wb_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == RQ_WB) |=> (req_ready && !out_valid));

  assert_reply_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_kind == MS_DATA) |=> (req_ready && !out_valid));
endmodule

// File: tb/dir_home_ctrl_tb_top.sv
module dir_home_ctrl_tb_top;
  localparam int NPROC = 4;
  localparam int NBLK  = 16;
  localparam int DW    = 32;
  localparam int PW    = $clog2(NPROC);
  localparam int AW    = $clog2(NBLK);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [1:0]    req_kind = '0;
  logic [PW-1:0] req_proc = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          out_valid, out_ready = 1'b0;
  logic [1:0]    out_kind;
  logic [PW-1:0] out_dest;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;
  logic          rsp_valid = 1'b0, rsp_ready;
  logic [DW-1:0] rsp_data = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;

  logic [DW-1:0] tb_mem [NBLK];
  assign mem_rdata = tb_mem[mem_addr];
  always @(posedge clk) if (mem_we) tb_mem[mem_addr] <= mem_wdata;

  dir_home_ctrl #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_proc(req_proc), .req_addr(req_addr), .req_data(req_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_dest(out_dest), .out_addr(out_addr), .out_data(out_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata));

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  int            m_st  [NBLK];
  int            m_sh  [NBLK];
  logic [DW-1:0] m_mem [NBLK];
  logic [DW-1:0] m_own [NBLK];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int low_of(input int v);
    for (int i = 0; i < NPROC; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic expect_msg(input logic [1:0] k, input int dest, input int a,
                            input logic [DW-1:0] d, input string tag);
    logic [63:0] exp, act, prev;
    bit held;
    held = 0;
    prev = '0;
    exp = {k, 6'(dest), 8'(a), d};
    forever begin
      @(negedge clk);
      act = {out_kind, 6'(out_dest), 8'(out_addr), out_data};
      if (held) check(out_valid && act == prev, "R11", act, prev);
      out_ready = ($urandom % 3) != 0;
      if (out_valid && out_ready) break;
      held = out_valid;
      prev = act;
    end
    check(act == exp, tag, act, exp);
    @(posedge clk);
  endtask

  task automatic give_rsp(input logic [DW-1:0] d);
    @(negedge clk);
    out_ready = 1'b0;
    rsp_valid = 1'b1;
    rsp_data  = d;
    while (!rsp_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic run_req(input int k, input int p, input int a, input logic [DW-1:0] d);
    int st, sh, own;
    logic [DW-1:0] v;
    st = m_st[a];
    sh = m_sh[a];
    own = low_of(sh);
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = 2'(k);
    req_proc  = PW'(p);
    req_addr  = AW'(a);
    req_data  = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (k == 0 || k == 1) check(!req_ready, "R10", 64'(req_ready), 64'd0);
    if (k == 0) begin
      if (st == 2) begin
        expect_msg(2'd1, own, a, '0, "R6");
        v = m_own[a];
        give_rsp(v);
        expect_msg(2'd3, p, a, v, "R6");
        m_mem[a] = v;
        m_sh[a] = sh | (1 << p);
      end else begin
        expect_msg(2'd3, p, a, m_mem[a], st == 0 ? "R2" : "R4");
        m_sh[a] = (st == 0) ? (1 << p) : (sh | (1 << p));
      end
      m_st[a] = 1;
    end else if (k == 1) begin
      if (st == 2) begin
        expect_msg(2'd2, own, a, '0, "R7");
        v = m_own[a];
        give_rsp(v);
        expect_msg(2'd3, p, a, v, "R7");
      end else begin
        if (st == 1)
          for (int i = 0; i < NPROC; i++)
            if (sh[i] && i != p) expect_msg(2'd0, i, a, '0, "R5");
        expect_msg(2'd3, p, a, m_mem[a], st == 0 ? "R3" : "R5");
      end
      m_st[a] = 2;
      m_sh[a] = 1 << p;
      m_own[a] = $urandom;
    end else if (k == 2 && st == 2 && sh == (1 << p)) begin
      m_mem[a] = d;
      m_st[a] = 0;
      m_sh[a] = 0;
    end
    @(negedge clk);
    out_ready = 1'b0;
    check(req_ready && !out_valid, (k >= 2) ? "R9" : "R10",
          {62'd0, req_ready, out_valid}, 64'd2);
    check(tb_mem[a] == m_mem[a], (k == 2) ? "R8" : (k == 3) ? "R9" : "R6", tb_mem[a], m_mem[a]);
  endtask

  initial begin
    for (int b = 0; b < NBLK; b++) begin
      tb_mem[b] = $urandom;
      m_mem[b]  = tb_mem[b];
      m_st[b] = 0;
      m_sh[b] = 0;
      m_own[b] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !out_valid && !mem_we, "R1", {61'd0, req_ready, out_valid, mem_we}, 64'd4);

    run_req(0, 0, 1, '0);
    run_req(0, 2, 1, '0);
    run_req(1, 1, 1, '0);
    run_req(0, 3, 1, '0);
    run_req(2, 3, 1, 32'hDEAD0001);
    run_req(1, 3, 1, '0);
    run_req(2, 0, 1, 32'hDEAD0002);
    run_req(1, 0, 1, '0);
    run_req(2, 0, 1, m_own[1]);
    run_req(1, 2, 5, '0);
    run_req(3, 1, 5, 32'hDEAD0003);
    run_req(0, 1, 5, '0);
    run_req(1, 1, 5, '0);

    for (int n = 0; n < 400; n++) begin
      int k, p, a;
      k = $urandom % 4;
      p = $urandom % NPROC;
      a = $urandom % 4;
      if (k < 2 && m_st[a] == 2 && m_sh[a] == (1 << p)) k = 2;
      run_req(k, p, a, (k == 2 && m_st[a] == 2 && m_sh[a] == (1 << p)) ? m_own[a] : $urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule